// File: doc/BRIEF.md
# SPI Transmit Holding and Shift Path

This block is the transmit half of an SPI peripheral. The host writes a data word into a holding register. When the serial side reaches a frame boundary, the word moves into a separate shift buffer. It is then sent out one bit per serial-clock strobe. Because the holding register and the shift buffer are separate, the host can queue the next word while the current frame is still shifting. A following frame can then start on the very next strobe, with no idle bit between frames.

A transmit-empty flag reports that the holding register is free. The flag is high out of reset. A host write drops it, and it rises again in the cycle after the serial side takes the word. An interrupt output follows the flag when its enable input is set. The frame length (8 or 16 bits) and the bit order (most or least significant bit first) can be changed at run time. They are sampled when a word is taken into the shift buffer. Shifting advances only on cycles where both the peripheral enable and the serial-clock strobe are high. Chip-select generation, baud-rate division, CRC and DMA requests are handled elsewhere.

Top module: `spi_tx_path`

## Requirements
- R1: After reset, `tx_empty` is 1 and `mosi` is 0, and no frame is in progress.
- R2: A cycle with `wr_en` high stores `wr_data` in the holding register, and `tx_empty` reads 0 from the next cycle. A write made while `tx_empty` is 0 replaces the pending word, so only the last word written is sent.
- R3: A step is a cycle with `en` and `sck_en` both high. On a step with no frame in progress and the holding register full, the word is taken into the shift buffer. In the next cycle the first bit of the frame is on `mosi`, and `tx_empty` is 1 unless a write arrived in the step cycle.
- R4: With `lsb_first` = 0 the bits go out from bit N-1 down to bit 0. With `lsb_first` = 1 they go out from bit 0 up to bit N-1. N is the frame length.
- R5: With `frame16` = 1 a frame is 16 bits long. With `frame16` = 0 it is 8 bits long and uses `wr_data[7:0]`; bits 15:8 of the word have no effect on `mosi`.
- R6: Each step presents exactly one further bit, one cycle after the step. A cycle that is not a step leaves `mosi` and the frame position unchanged, so a frame pauses while `en` is 0.
- R7: If the holding register is full when the last bit of a frame has been presented, the next step starts the next frame. No gap bit is inserted.
- R8: If the holding register is empty when a frame ends, shifting stops and `mosi` keeps the last bit sent until a new word is taken.
- R9: `tx_irq` equals `tx_empty` AND `empty_ie`, in the same cycle.
- R10: `lsb_first` and `frame16` are sampled only when a word is taken. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Peripheral enable; shifting only while high |
| sck_en | input | 1 | Serial-clock strobe, one bit per strobe |
| lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| frame16 | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| empty_ie | input | 1 | Empty-interrupt enable |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 16 | Host write data |
| mosi | output | 1 | Serial data out |
| tx_empty | output | 1 | Holding register is free for a new word |
| tx_irq | output | 1 | Empty interrupt request |

## Verification
Each result has a fixed latency:
- A write makes `tx_empty` fall one cycle later.
- A step that takes a word puts the first bit on `mosi` and raises `tx_empty` one cycle later.
- Every later step moves `mosi` to the next bit one cycle later.
- `tx_irq` follows `tx_empty` in the same cycle.

The bench drives inputs on the falling edge. A behavioural model, built on a bit queue, updates on each rising edge with exactly these latencies. On every falling edge, before new inputs are applied, the model is compared with `mosi`, `tx_empty` and `tx_irq`. Short directed checks at fixed cycle offsets cover the reset state, the flag drop after a write, and the interrupt gating.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  localparam int TX_WORD_W  = 16;
  localparam int TX_SHORT_W = 8;

  typedef enum logic {ORDER_MSB = 1'b0, ORDER_LSB = 1'b1} tx_order_e;
  typedef enum logic {LEN_SHORT = 1'b0, LEN_FULL = 1'b1} tx_len_e;
endpackage

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
  parameter int DATA_W = spi_tx_pkg::TX_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty
);
  // A host write wins over a take in the same cycle.
  // The shift side has already copied the old word in that cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      empty     <= 1'b1;
    end else if (wr_en) begin
      hold_data <= wr_data;
      empty     <= 1'b0;
    end else if (take) begin
      empty     <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_tx_pkg::*;
#(
  parameter int DATA_W  = TX_WORD_W,
  parameter int SHORT_W = TX_SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_full,
  input  logic              lsb_first,
  input  logic              frame16,
  output logic              mosi,
  output logic              load_evt,
  output logic              idle
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  // Number of bits in one frame for the selected length.
  function automatic logic [CNT_W-1:0] frame_bits(input tx_len_e len_sel);
    return (len_sel == LEN_FULL) ? CNT_W'(DATA_W) : CNT_W'(SHORT_W);
  endfunction

  // Arrange the word so that the bit to send next is always in the top position.
  function automatic logic [DATA_W-1:0] line_up(input logic [DATA_W-1:0] d,
                                                input tx_order_e order,
                                                input tx_len_e len_sel);
    logic [DATA_W-1:0] s;
    int len;
    s   = '0;
    len = (len_sel == LEN_FULL) ? DATA_W : SHORT_W;
    for (int k = 0; k < DATA_W; k++) begin
      if (k < len) begin
        s[DATA_W-1-k] = (order == ORDER_LSB) ? d[k] : d[len-1-k];
      end
    end
    return s;
  endfunction

  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  bits_left;
  logic [DATA_W-1:0] seq;
  tx_order_e         order_sel;
  tx_len_e           len_sel;

  assign order_sel = tx_order_e'(lsb_first);
  assign len_sel   = tx_len_e'(frame16);
  assign seq       = line_up(hold_data, order_sel, len_sel);
  assign idle      = (bits_left == '0);
  assign load_evt  = step && idle && hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      bits_left <= '0;
      mosi      <= 1'b0;
    end else if (load_evt) begin
      mosi      <= seq[DATA_W-1];
      sreg      <= seq << 1;
      bits_left <= frame_bits(len_sel) - CNT_W'(1);
    end else if (step && !idle) begin
      mosi      <= sreg[DATA_W-1];
      sreg      <= sreg << 1;
      bits_left <= bits_left - CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_tx_irq.sv
module spi_tx_irq (
  input  logic empty,
  input  logic irq_en,
  output logic irq
);
  assign irq = empty & irq_en;
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
  import spi_tx_pkg::*;
#(
  parameter int DATA_W  = TX_WORD_W,
  parameter int SHORT_W = TX_SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sck_en,
  input  logic              lsb_first,
  input  logic              frame16,
  input  logic              empty_ie,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mosi,
  output logic              tx_empty,
  output logic              tx_irq
);
  logic              step;
  logic              load_evt;
  logic              shift_idle;
  logic [DATA_W-1:0] hold_q;

  assign step = en & sck_en;

  spi_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (load_evt),
    .hold_data (hold_q),
    .empty     (tx_empty)
  );

  spi_tx_shift #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .hold_data (hold_q),
    .hold_full (!tx_empty),
    .lsb_first (lsb_first),
    .frame16   (frame16),
    .mosi      (mosi),
    .load_evt  (load_evt),
    .idle      (shift_idle)
  );

  spi_tx_irq u_irq (
    .empty  (tx_empty),
    .irq_en (empty_ie),
    .irq    (tx_irq)
  );
endmodule

// File: rtl/spi_tx_chk.sv
module spi_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sck_en,
  input logic wr_en,
  input logic mosi,
  input logic tx_empty,
  input logic tx_irq,
  input logic load_evt,
  input logic shift_idle
);
  // R2
  wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_empty);

  // R3
  take_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_en) |=> tx_empty);

  // R3
  take_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !tx_empty);

  // R6
  no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && sck_en) |=> $stable(mosi));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_idle && tx_empty) |=> $stable(mosi));

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_empty);
endmodule

bind spi_tx_path spi_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .sck_en     (sck_en),
  .wr_en      (wr_en),
  .mosi       (mosi),
  .tx_empty   (tx_empty),
  .tx_irq     (tx_irq),
  .load_evt   (load_evt),
  .shift_idle (shift_idle)
);

// File: tb/tb_spi_tx_path.sv
`timescale 1ns/1ps
module tb_spi_tx_path;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sck_en = 1'b0, lsb_first = 1'b0, frame16 = 1'b1, empty_ie = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic mosi, tx_empty, tx_irq;

  always #2.5 clk = ~clk; // 200 MHz

  spi_tx_path dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sck_en(sck_en), .lsb_first(lsb_first),
    .frame16(frame16), .empty_ie(empty_ie), .wr_en(wr_en), .wr_data(wr_data),
    .mosi(mosi), .tx_empty(tx_empty), .tx_irq(tx_irq)
  );

  int vectors = 0;
  int errors  = 0;
  int tick_div = 1;
  int phase = 0;
  int cycles = 0;

  // Behavioural reference model.
  bit   m_bits[$];
  int   m_hold = 0;
  bit   m_empty = 1'b1;
  bit   m_mosi = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bits.delete();
      m_hold = 0; m_empty = 1'b1; m_mosi = 1'b0;
    end else begin
      if (en && sck_en) begin
        if (m_bits.size() > 0) begin
          m_mosi = m_bits.pop_front();
        end else if (!m_empty) begin
          int n;
          n = frame16 ? 16 : 8;
          for (int i = 0; i < n; i++) begin
            if (lsb_first) m_bits.push_back(m_hold[i]);
            else           m_bits.push_back(m_hold[n-1-i]);
          end
          m_mosi = m_bits.pop_front();
          m_empty = 1'b1;
        end
      end
      if (wr_en) begin
        m_hold = wr_data;
        m_empty = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input string name, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, name, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R4 R5 R6", "mosi", int'(mosi), int'(m_mosi));
    check("R2 R3", "tx_empty", int'(tx_empty), int'(m_empty));
    check("R9", "tx_irq", int'(tx_irq), int'(m_empty & empty_ie));
  endtask

  task automatic step_cycle();
    @(negedge clk);
    compare_all();
    sck_en = (tick_div <= 1) ? 1'b1 : ((phase % tick_div) == 0);
    phase++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step_cycle();
  endtask

  task automatic write_word(input logic [15:0] d);
    int guard;
    guard = 0;
    while (!tx_empty && guard < 200) begin step_cycle(); guard++; end
    wr_en = 1'b1; wr_data = d;
    step_cycle();
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    empty_ie = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "tx_empty in reset", int'(tx_empty), 1);
    check("R1", "mosi in reset", int'(mosi), 0);
    check("R9", "irq in reset", int'(tx_irq), 1);
    @(negedge clk); rst_n = 1'b1;
    run(2);

    // R2: flag drops the cycle after a write (en low, nothing taken)
    wr_en = 1'b1; wr_data = 16'h1234;
    step_cycle();
    wr_en = 1'b0;
    check("R2", "tx_empty after write", int'(tx_empty), 0);
    check("R9", "irq low while full", int'(tx_irq), 0);
    // R2 overwrite while flag low: the second word replaces the first
    wr_en = 1'b1; wr_data = 16'hB00D;
    step_cycle();
    wr_en = 1'b0;
    // R3 R4 R5: 16-bit MSB-first frame at full rate
    en = 1'b1; frame16 = 1'b1; lsb_first = 1'b0; tick_div = 1;
    run(20);
    check("R8", "mosi holds after frame", int'(mosi), int'(m_mosi));

    // R7: back-to-back words, queued while a frame is shifting
    write_word(16'hA5C3);
    write_word(16'h0F0F);
    write_word(16'h8001);
    run(40);

    // R4 R5: 8-bit LSB-first with junk in the upper byte, slow strobe
    frame16 = 1'b0; lsb_first = 1'b1; tick_div = 3;
    write_word(16'hFF96);
    write_word(16'h0069);
    run(60);

    // R5: 8-bit MSB-first
    lsb_first = 1'b0; tick_div = 2;
    write_word(16'h5A3C);
    run(30);

    // R6: pause mid-frame by dropping enable
    frame16 = 1'b1; tick_div = 1;
    write_word(16'hC0DE);
    run(5);
    en = 1'b0;
    run(10);
    en = 1'b1;
    run(20);

    // R10: change order and length during a frame
    write_word(16'h3E71);
    run(3);
    frame16 = 1'b0; lsb_first = 1'b1;
    run(25);

    // R8: long idle with empty holding register
    tick_div = 1;
    run(30);

    // R9: interrupt gated off
    empty_ie = 1'b0;
    step_cycle();
    check("R9", "irq with enable off", int'(tx_irq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule